// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small stored-program processor built around one 32-bit accumulator. Code and data share one word-addressed memory, and every instruction fills exactly one word. Each instruction runs through a sequence of register transfers. The program counter is copied into the memory address register. The memory is read into the data register. The data register moves into the instruction register, and the counter advances by one word. Only then is the instruction decoded and carried out.

An instruction word carries its opcode in bits 31:24 and an address or literal field in bits 23:0. The core keeps three flags that describe the accumulator: zero, positive and negative, all signed. Three skip instructions test these flags. Characters come in on a valid/ready stream that can also signal end of input. Characters go out on a second valid/ready stream.

The program image is written through a preload port, normally while reset is held. After reset is released, execution starts at word 0 and runs until a halt.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `halted`, `out_valid` and `in_ready` are low. The first instruction executed after reset is the one at word address 0.
- R2: Opcode 0 (load literal) puts the 24-bit field of bits 23:0 into the accumulator, zero-extended to 32 bits.
- R3: Opcodes 1 (load), 3 (add), 4 (subtract), 12 (OR) and 13 (AND) read the word at the address in bits 23:0. They then set the accumulator to that word, or to accumulator plus, minus, OR or AND that word, with 32-bit wrap-around.
- R4: Opcode 2 (store) writes the accumulator to memory at the address field. A later load from that address returns the stored value.
- R5: Opcode 14 replaces the accumulator with its bitwise complement.
- R6: Opcode 8 (jump) continues execution at the address field. The instructions between the jump and its target do not execute.
- R7: Opcodes 9, 10 and 11 skip the next instruction when the accumulator is zero, signed positive (non-zero with bit 31 clear) or signed negative (bit 31 set), respectively. When the condition does not hold, the next instruction executes.
- R8: Opcode 5 (input) raises `in_ready` and waits with no progress until `in_valid`. It then loads `in_data` zero-extended, or all ones when `in_eof` is high. `in_ready` stays high until the transfer.
- R9: Opcode 6 (output) presents accumulator bits 7:0 on `out_data` with `out_valid`. It holds both stable and makes no progress until `out_ready`.
- R10: Opcode 7, and every opcode from 15 to 255, halts the core. `halted` then stays high and no memory access occurs until reset.
- R11: A cycle with `pre_we` high writes `pre_wdata` to memory word `pre_addr`. Reset does not clear the memory, so a rewritten word takes effect on the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write strobe, has priority over the core |
| pre_addr | input | ADDR_W | Preload word address |
| pre_wdata | input | DATA_W | Preload write data |
| in_valid | input | 1 | Input character or end-of-input available |
| in_eof | input | 1 | End of input; qualifies `in_valid` |
| in_data | input | CHAR_W | Input character |
| in_ready | output | 1 | Core is waiting for an input transfer |
| out_valid | output | 1 | Output character available |
| out_data | output | CHAR_W | Output character (accumulator low byte) |
| out_ready | input | 1 | Receiver accepts the output character |
| halted | output | 1 | Core has stopped |

## Verification
The skip tests cover every flag from both sides, including zero, which is neither positive nor negative, and all ones, which is negative. A core that computed the positive flag from bit 31 alone would skip on zero and print one character too few. The end-of-input test complements the loaded value and skips on zero, so a core that returned only eight ones would print an extra byte. Input 0x80 followed by a positive-skip exposes sign extension of input characters. Output and input stalls of many cycles are held to catch a core that drops `out_valid`, changes `out_data` or runs ahead. An undefined opcode must stop the run, and a core that treated it as a no-op would emit a further character.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_LIT = 8'd0,
    OP_LOD = 8'd1,
    OP_STO = 8'd2,
    OP_ADD = 8'd3,
    OP_SUB = 8'd4,
    OP_CIN = 8'd5,
    OP_COU = 8'd6,
    OP_HLT = 8'd7,
    OP_JMP = 8'd8,
    OP_SKZ = 8'd9,
    OP_SKG = 8'd10,
    OP_SKL = 8'd11,
    OP_OR  = 8'd12,
    OP_AND = 8'd13,
    OP_NOT = 8'd14
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FADDR,   // MAR <- PC
    ST_FREAD,   // memory read at MAR
    ST_FLATCH,  // MDR <- memory
    ST_FLOAD,   // IR <- MDR, PC <- PC + 1
    ST_DECODE,  // decode and short instructions
    ST_OREAD,   // operand read at MAR
    ST_OLATCH,  // MDR <- memory
    ST_OEXEC,   // ACCUM <- f(ACCUM, MDR)
    ST_STORE,   // memory[MAR] <- MDR
    ST_INPUT,   // wait for input transfer
    ST_OUTPUT,  // wait for output transfer
    ST_HALT
  } state_e;

  typedef struct packed {
    logic zero;
    logic pos;
    logic neg;
  } flags_t;

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store_q [DEPTH];

  // Single port, read-before-write, registered read data.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store_q[addr] <= wdata;
      rdata <= store_q[addr];
    end
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  opcode_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_ADD:  res = acc + opnd;
      OP_SUB:  res = acc - opnd;
      OP_OR:   res = acc | opnd;
      OP_AND:  res = acc & opnd;
      OP_NOT:  res = ~acc;
      default: res = opnd;  // plain load
    endcase
  end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  input  logic              in_eof,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  output logic              halted,
  output opcode_e           alu_op,
  output logic [DATA_W-1:0] alu_acc,
  output logic [DATA_W-1:0] alu_opnd,
  input  logic [DATA_W-1:0] alu_res
);
  localparam int FLD_W = DATA_W - OPC_W;

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
  flags_t            flg_q;
  logic              in_ready_q, out_valid_q, halted_q;
  logic [CHAR_W-1:0] out_data_q;

  opcode_e           op;
  logic [FLD_W-1:0]  fld;
  logic [ADDR_W-1:0] fld_addr;
  logic              acc_we;
  logic [DATA_W-1:0] acc_nxt;
  logic              skip_hit;

  assign op       = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);
  assign fld      = ir_q[FLD_W-1:0];
  assign fld_addr = fld[ADDR_W-1:0];

  assign alu_op   = op;
  assign alu_acc  = acc_q;
  assign alu_opnd = mdr_q;

  assign mem_en    = (state_q == ST_FREAD) || (state_q == ST_OREAD) || (state_q == ST_STORE);
  assign mem_we    = (state_q == ST_STORE);
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;

  assign in_ready  = in_ready_q;
  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign halted    = halted_q;

  function automatic flags_t classify(input logic [DATA_W-1:0] v);
    flags_t f;
    f.zero = (v == '0);
    f.neg  = v[DATA_W-1];
    f.pos  = !f.zero && !f.neg;
    return f;
  endfunction

  always_comb begin
    unique case (op)
      OP_SKZ:  skip_hit = flg_q.zero;
      OP_SKG:  skip_hit = flg_q.pos;
      OP_SKL:  skip_hit = flg_q.neg;
      default: skip_hit = 1'b0;
    endcase
  end

  // Accumulator write source.
  always_comb begin
    acc_we  = 1'b0;
    acc_nxt = alu_res;
    case (state_q)
      ST_DECODE: begin
        if (op == OP_LIT) begin
          acc_we  = 1'b1;
          acc_nxt = {{OPC_W{1'b0}}, fld};
        end else if (op == OP_NOT) begin
          acc_we = 1'b1;
        end
      end
      ST_OEXEC: acc_we = 1'b1;
      ST_INPUT: begin
        if (in_valid) begin
          acc_we  = 1'b1;
          acc_nxt = in_eof ? '1 : {{(DATA_W-CHAR_W){1'b0}}, in_data};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      flg_q <= '{zero: 1'b1, pos: 1'b0, neg: 1'b0};
    end else if (acc_we) begin
      acc_q <= acc_nxt;
      flg_q <= classify(acc_nxt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_FADDR;
      pc_q        <= '0;
      mar_q       <= '0;
      mdr_q       <= '0;
      ir_q        <= '0;
      in_ready_q  <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      halted_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_FADDR: begin
          mar_q   <= pc_q;
          state_q <= ST_FREAD;
        end
        ST_FREAD:  state_q <= ST_FLATCH;
        ST_FLATCH: begin
          mdr_q   <= mem_rdata;
          state_q <= ST_FLOAD;
        end
        ST_FLOAD: begin
          ir_q    <= mdr_q;
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          state_q <= ST_FADDR;
          case (op)
            OP_LIT, OP_NOT: ;
            OP_LOD, OP_ADD, OP_SUB, OP_OR, OP_AND: begin
              mar_q   <= fld_addr;
              state_q <= ST_OREAD;
            end
            OP_STO: begin
              mar_q   <= fld_addr;
              mdr_q   <= acc_q;
              state_q <= ST_STORE;
            end
            OP_CIN: begin
              in_ready_q <= 1'b1;
              state_q    <= ST_INPUT;
            end
            OP_COU: begin
              out_valid_q <= 1'b1;
              out_data_q  <= acc_q[CHAR_W-1:0];
              state_q     <= ST_OUTPUT;
            end
            OP_JMP: pc_q <= fld_addr;
            OP_SKZ, OP_SKG, OP_SKL: begin
              if (skip_hit) pc_q <= pc_q + 1'b1;
            end
            default: begin  // HLT and every undefined opcode
              halted_q <= 1'b1;
              state_q  <= ST_HALT;
            end
          endcase
        end
        ST_OREAD:  state_q <= ST_OLATCH;
        ST_OLATCH: begin
          mdr_q   <= mem_rdata;
          state_q <= ST_OEXEC;
        end
        ST_OEXEC:  state_q <= ST_FADDR;
        ST_STORE:  state_q <= ST_FADDR;
        ST_INPUT: begin
          if (in_valid) begin
            in_ready_q <= 1'b0;
            state_q    <= ST_FADDR;
          end
        end
        ST_OUTPUT: begin
          if (out_ready) begin
            out_valid_q <= 1'b0;
            state_q     <= ST_FADDR;
          end
        end
        default: begin
          halted_q <= 1'b1;
          state_q  <= ST_HALT;
        end
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_wdata,
  input  logic              in_valid,
  input  logic              in_eof,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  output logic              halted
);
  logic              core_mem_en, core_mem_we;
  logic [ADDR_W-1:0] core_mem_addr;
  logic [DATA_W-1:0] core_mem_wdata, ram_rdata;
  logic              ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  opcode_e           alu_op;
  logic [DATA_W-1:0] alu_acc, alu_opnd, alu_res;

  // The preload port wins the single memory port.
  assign ram_en    = pre_we | core_mem_en;
  assign ram_we    = pre_we | core_mem_we;
  assign ram_addr  = pre_we ? pre_addr  : core_mem_addr;
  assign ram_wdata = pre_we ? pre_wdata : core_mem_wdata;

  acc_cpu_ram #(.W(DATA_W), .AW(ADDR_W)) i_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  acc_cpu_alu #(.W(DATA_W)) i_alu (
    .op   (alu_op),
    .acc  (alu_acc),
    .opnd (alu_opnd),
    .res  (alu_res)
  );

  acc_cpu_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .mem_en    (core_mem_en),
    .mem_we    (core_mem_we),
    .mem_addr  (core_mem_addr),
    .mem_wdata (core_mem_wdata),
    .mem_rdata (ram_rdata),
    .in_valid  (in_valid),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .halted    (halted),
    .alu_op    (alu_op),
    .alu_acc   (alu_acc),
    .alu_opnd  (alu_opnd),
    .alu_res   (alu_res)
  );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic              core_mem_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CHAR_W-1:0] out_data
);
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !core_mem_en);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  // R8
  io_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
endmodule

bind acc_cpu_core acc_cpu_chk #(.CHAR_W(CHAR_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .halted      (halted),
  .core_mem_en (core_mem_en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/test_acc_cpu_core.sv
`timescale 1ns/1ps
module test_acc_cpu_core;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_wdata = '0;
  logic          in_valid = 1'b0, in_eof = 1'b0;
  logic [CW-1:0] in_data = '0;
  logic          in_ready, out_valid, halted;
  logic [CW-1:0] out_data;
  logic          out_ready = 1'b1;

  int checks = 0, failures = 0, cyc = 0;
  logic [8:0] in_q[$];
  logic [7:0] out_q[$];
  logic [7:0] exp_q[$];
  logic       in_hs = 1'b0, out_hs = 1'b0;
  logic [7:0] out_cap = '0;
  bit         feed_on = 1'b1;

  acc_cpu_core #(.DATA_W(DW), .ADDR_W(AW), .CHAR_W(CW)) i_acc_cpu_core (
    .clk, .rst, .pre_we, .pre_addr, .pre_wdata,
    .in_valid, .in_eof, .in_data, .in_ready,
    .out_valid, .out_data, .out_ready, .halted
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    in_hs   <= in_valid && in_ready;
    out_hs  <= out_valid && out_ready && !rst;
    out_cap <= out_data;
    cyc     <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (in_hs && in_q.size() > 0) void'(in_q.pop_front());
    if (out_hs) out_q.push_back(out_cap);
    in_valid = feed_on && (in_q.size() > 0);
    in_eof   = (in_q.size() > 0) ? in_q[0][8] : 1'b0;
    in_data  = (in_q.size() > 0) ? in_q[0][7:0] : 8'h00;
  end

  function automatic logic [31:0] w(input int op, input int fld);
    return {op[7:0], fld[23:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    in_q.delete();
    exp_q.delete();
    @(negedge clk);
    out_q.delete();
  endtask

  task automatic put(input int a, input logic [31:0] d);
    pre_we = 1'b1; pre_addr = a[AW-1:0]; pre_wdata = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic go();
    rst = 1'b0;
  endtask

  task automatic run(input string tag);
    int n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    check(halted === 1'b1, {tag, " halt reached"}, {31'd0, halted}, 32'd1);
  endtask

  task automatic cmp_out(input string tag);
    check(out_q.size() == exp_q.size(), {tag, " output count"}, out_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < out_q.size(); k++)
      check(out_q[k] == exp_q[k], {tag, " output byte"}, {24'd0, out_q[k]}, {24'd0, exp_q[k]});
  endtask

  // R1: reset values; start at word 0
  task automatic t_reset();
    begin_prog();
    put(0, w(0, 'h52)); put(1, w(6, 0)); put(2, w(7, 0));
    check(!halted && !out_valid && !in_ready, "R1 outputs in reset",
          {29'd0, halted, out_valid, in_ready}, 32'd0);
    go();
    @(negedge clk);
    check(!halted && !out_valid && !in_ready, "R1 outputs after release",
          {29'd0, halted, out_valid, in_ready}, 32'd0);
    run("R1");
    exp_q.push_back(8'h52);
    cmp_out("R1 first word");
  endtask

  // R2, R9: literal zero-extension and low-byte output
  task automatic t_literal();
    begin_prog();
    put(0, w(0, 'h41)); put(1, w(6, 0));
    put(2, w(0, 'hABCDEF)); put(3, w(6, 0));
    put(4, w(0, 'hFFFFFF)); put(5, w(10, 0)); put(6, w(0, 'h58)); put(7, w(6, 0));
    put(8, w(7, 0));
    go();
    run("R2");
    exp_q.push_back(8'h41); exp_q.push_back(8'hEF); exp_q.push_back(8'hFF);
    cmp_out("R2 literal");  // 0xFFFFFF zero-extended is positive: skip taken
  endtask

  // R3, R5: memory operand arithmetic and complement
  task automatic t_alu();
    begin_prog();
    put('h80, 32'd5); put('h81, 32'd3); put('h82, 32'hF0);
    put(0, w(1, 'h80)); put(1, w(3, 'h81)); put(2, w(6, 0));
    put(3, w(4, 'h81)); put(4, w(6, 0));
    put(5, w(12, 'h82)); put(6, w(6, 0));
    put(7, w(13, 'h82)); put(8, w(6, 0));
    put(9, w(14, 0)); put(10, w(6, 0));
    put(11, w(0, 0)); put(12, w(4, 'h81)); put(13, w(6, 0));
    put(14, w(14, 0)); put(15, w(6, 0));
    put(16, w(7, 0));
    go();
    run("R3");
    exp_q.push_back(8'h08); exp_q.push_back(8'h05); exp_q.push_back(8'hF5);
    exp_q.push_back(8'hF0); exp_q.push_back(8'h0F); exp_q.push_back(8'hFD);
    exp_q.push_back(8'h02);
    cmp_out("R3 R5 alu");
  endtask

  // R4: store then load back
  task automatic t_store();
    begin_prog();
    put('h90, 32'h0);
    put(0, w(0, 'h5A)); put(1, w(2, 'h90)); put(2, w(0, 0));
    put(3, w(1, 'h90)); put(4, w(6, 0)); put(5, w(7, 0));
    go();
    run("R4");
    exp_q.push_back(8'h5A);
    cmp_out("R4 store");
  endtask

  // R6: jump over code
  task automatic t_jump();
    begin_prog();
    put(0, w(8, 3)); put(1, w(0, 'h31)); put(2, w(6, 0));
    put(3, w(0, 'h33)); put(4, w(6, 0)); put(5, w(7, 0));
    go();
    run("R6");
    exp_q.push_back(8'h33);
    cmp_out("R6 jump");
  endtask

  // R7: each skip taken and not taken
  task automatic t_skip();
    int a = 0;
    begin_prog();
    // zero, SKZ taken
    put(a++, w(0, 0)); put(a++, w(9, 0)); put(a++, w(6, 0)); put(a++, w(0, 'h61)); put(a++, w(6, 0));
    // five, SKZ not taken
    put(a++, w(0, 5)); put(a++, w(9, 0)); put(a++, w(6, 0)); put(a++, w(0, 'h62)); put(a++, w(6, 0));
    // five, SKG taken
    put(a++, w(0, 5)); put(a++, w(10, 0)); put(a++, w(6, 0)); put(a++, w(0, 'h63)); put(a++, w(6, 0));
    // zero, SKG not taken
    put(a++, w(0, 0)); put(a++, w(10, 0)); put(a++, w(6, 0)); put(a++, w(0, 'h64)); put(a++, w(6, 0));
    // minus one, SKL taken
    put(a++, w(0, 0)); put(a++, w(14, 0)); put(a++, w(11, 0)); put(a++, w(6, 0)); put(a++, w(0, 'h65)); put(a++, w(6, 0));
    // seven, SKL not taken
    put(a++, w(0, 7)); put(a++, w(11, 0)); put(a++, w(6, 0)); put(a++, w(0, 'h66)); put(a++, w(6, 0));
    // minus one, SKG not taken
    put(a++, w(0, 0)); put(a++, w(14, 0)); put(a++, w(10, 0)); put(a++, w(6, 0)); put(a++, w(0, 'h67)); put(a++, w(6, 0));
    // zero, SKL not taken
    put(a++, w(0, 0)); put(a++, w(11, 0)); put(a++, w(6, 0)); put(a++, w(0, 'h68)); put(a++, w(6, 0));
    put(a++, w(7, 0));
    go();
    run("R7");
    exp_q.push_back(8'h61);
    exp_q.push_back(8'h05); exp_q.push_back(8'h62);
    exp_q.push_back(8'h63);
    exp_q.push_back(8'h00); exp_q.push_back(8'h64);
    exp_q.push_back(8'h65);
    exp_q.push_back(8'h07); exp_q.push_back(8'h66);
    exp_q.push_back(8'hFF); exp_q.push_back(8'h67);
    exp_q.push_back(8'h00); exp_q.push_back(8'h68);
    cmp_out("R7 skips");
  endtask

  // R8: input stall, zero extension, end of input as all ones
  task automatic t_input();
    int n = 0;
    begin_prog();
    put(0, w(5, 0)); put(1, w(6, 0));
    put(2, w(5, 0)); put(3, w(10, 0)); put(4, w(6, 0)); put(5, w(6, 0));
    put(6, w(5, 0)); put(7, w(14, 0)); put(8, w(9, 0)); put(9, w(6, 0));
    put(10, w(0, 'h4B)); put(11, w(6, 0)); put(12, w(7, 0));
    feed_on = 1'b0;
    in_q.push_back({1'b0, 8'h68});
    in_q.push_back({1'b0, 8'h80});
    in_q.push_back({1'b1, 8'h00});
    go();
    while (!in_ready && n < 200) begin @(negedge clk); n++; end
    repeat (12) @(negedge clk);
    check(in_ready === 1'b1, "R8 ready held while stalled", {31'd0, in_ready}, 32'd1);
    check(out_q.size() == 0 && !halted, "R8 no progress while stalled", out_q.size(), 32'd0);
    feed_on = 1'b1;
    run("R8");
    exp_q.push_back(8'h68); exp_q.push_back(8'h80); exp_q.push_back(8'h4B);
    cmp_out("R8 input");
  endtask

  // R9: output stall holds the character
  task automatic t_output();
    int n = 0;
    bit held = 1'b1;
    begin_prog();
    put(0, w(0, 'h77)); put(1, w(6, 0)); put(2, w(0, 'h11)); put(3, w(6, 0)); put(4, w(7, 0));
    out_ready = 1'b0;
    go();
    while (!out_valid && n < 200) begin @(negedge clk); n++; end
    check(out_data == 8'h77, "R9 presented byte", {24'd0, out_data}, 32'h77);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!out_valid || out_data != 8'h77 || halted) held = 1'b0;
    end
    check(held, "R9 held during stall", {31'd0, held}, 32'd1);
    out_ready = 1'b1;
    run("R9");
    exp_q.push_back(8'h77); exp_q.push_back(8'h11);
    cmp_out("R9 output");
  endtask

  // R10: undefined opcode halts and stays halted
  task automatic t_undef();
    bit stay = 1'b1;
    begin_prog();
    put(0, w(0, 'h21)); put(1, w(6, 0)); put(2, w('h2A, 0));
    put(3, w(0, 'h22)); put(4, w(6, 0)); put(5, w(7, 0));
    go();
    run("R10");
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!halted) stay = 1'b0;
    end
    check(stay, "R10 halt sticky", {31'd0, stay}, 32'd1);
    exp_q.push_back(8'h21);
    cmp_out("R10 undefined opcode");
  endtask

  // R11: rewritten word takes effect on the next run; R1 restart at 0
  task automatic t_reload();
    begin_prog();
    put(0, w(0, 'h31)); put(1, w(6, 0)); put(2, w(7, 0));
    go();
    run("R11 first");
    begin_prog();
    put(0, w(0, 'h32));
    go();
    run("R11 second");
    exp_q.push_back(8'h32);
    cmp_out("R11 reload");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_literal();
    t_alu();
    t_store();
    t_jump();
    t_skip();
    t_input();
    t_output();
    t_undef();
    t_reload();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule